// File: doc/BRIEF.md
# Configurable Ready/Busy Status Pin Controller

This block drives one status output for a memory controller. In its default level mode the pin reports whether the program/erase engine is working. Software can switch it into one of three pulse modes. In a pulse mode the pin stays high and drops low for a fixed time each time a selected completion event occurs: an erase finishing, a program finishing, or either of them.

The mode is chosen by a two-write command on the controller's command bus. The first write carries a setup code. The second write carries the mode code. The command is refused while the engine is busy or an operation is suspended. A mode code outside the valid set raises an error flag that feeds the status register.

The pulse width is set in nanoseconds together with the clock frequency, and the block derives the cycle count from them. Electrical drive is outside the block. The output is a logic level only.

Top module: `stsig_pin_ctrl`

## Requirements
- R1: After reset the mode is level (code 0), `cfg_err` is 0 and no pulse is in progress.
- R2: In level mode `sts_pin` is 0 while `ctl_busy` is 1 and 1 otherwise, in the same cycle. Completion strobes have no effect in this mode.
- R3: A write of `SETUP_CODE` while idle, followed by a write whose data is 0, 1, 2 or 3, selects a mode. The codes are: 0 level, 1 pulse on erase completion, 2 pulse on program completion, 3 pulse on either. A successful selection clears `cfg_err`.
- R4: If `ctl_busy` or `ctl_susp` is 1 at either write of the command, that write changes neither the mode nor `cfg_err`. A rejected second write ends the command.
- R5: A second write with data greater than 3 sets `cfg_err` and keeps the current mode.
- R6: `cfg_err` stays set until a later successful mode selection.
- R7: In mode 1, an `erase_done` strobe drives `sts_pin` low for exactly PULSE_CYC cycles, starting in the cycle after the strobe's clock edge. `prog_done` has no effect in this mode.
- R8: In mode 2, `prog_done` starts the pulse and `erase_done` has no effect.
- R9: In mode 3, either strobe starts the pulse.
- R10: In a pulse mode, `ctl_busy` has no effect on `sts_pin`.
- R11: A qualifying strobe during an active pulse restarts the full pulse width.
- R12: A write that is not `SETUP_CODE` while idle has no effect. After a rejected command, the next write is again decoded as a first write.
- R13: A successful mode selection ends any pulse in progress at the same clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_wr | input | 1 | Command write strobe, one cycle per bus write |
| cmd_data | input | CMD_W | Command write data |
| ctl_busy | input | 1 | Program/erase engine busy |
| ctl_susp | input | 1 | An operation is suspended |
| erase_done | input | 1 | One-cycle erase completion strobe |
| prog_done | input | 1 | One-cycle program completion strobe |
| sts_pin | output | 1 | Status pin level |
| cfg_err | output | 1 | Configuration error flag for the status register |

## Verification
The bench sweeps every one of the 256 values of the second write. After each one it identifies the resulting mode only from the pin: it raises busy, then sends an erase strobe, then a program strobe. This separates valid codes from invalid ones and separates each of the four modes from the others. Configure attempts are made with busy set or suspend set at each of the two writes, and with stray writes while idle. These patterns show whether a refusal leaves both the mode and the error flag untouched. Pulse widths are measured by counting low samples for a single strobe and for a strobe repeated mid-pulse. One further run selects a new mode while a pulse is active, which shows whether the pulse is cut off.

// File: rtl/stsig_pkg.sv
package stsig_pkg;

   typedef enum logic [1:0] {
      MODE_LEVEL = 2'd0,
      MODE_ERASE = 2'd1,
      MODE_PROG  = 2'd2,
      MODE_ANY   = 2'd3
   } sts_mode_e;

   function automatic logic erase_selected(sts_mode_e m);
      return (m == MODE_ERASE) || (m == MODE_ANY);
   endfunction

   function automatic logic prog_selected(sts_mode_e m);
      return (m == MODE_PROG) || (m == MODE_ANY);
   endfunction

endpackage

// File: rtl/stsig_cmd_dec.sv
module stsig_cmd_dec
   import stsig_pkg::*;
#(
   parameter int unsigned CMD_W      = 8,
   parameter logic [CMD_W-1:0] SETUP_CODE = 8'hB8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cmd_wr,
   input  logic [CMD_W-1:0] cmd_data,
   input  logic             ctl_busy,
   input  logic             ctl_susp,
   output sts_mode_e        mode_o,
   output logic             err_o,
   output logic             take_o
);

   localparam logic [CMD_W-1:0] MAX_CODE = CMD_W'(3);

   logic      armed_q;
   sts_mode_e mode_q;
   logic      err_q;
   logic      idle_ok;
   logic      code_ok;

   assign idle_ok = !ctl_busy && !ctl_susp;
   assign code_ok = (cmd_data <= MAX_CODE);
   assign take_o  = cmd_wr && armed_q && idle_ok && code_ok;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         armed_q <= 1'b0;
         mode_q  <= MODE_LEVEL;
         err_q   <= 1'b0;
      end else if (cmd_wr) begin
         if (armed_q) begin
            armed_q <= 1'b0;
            if (idle_ok) begin
               if (code_ok) begin
                  mode_q <= sts_mode_e'(cmd_data[1:0]);
                  err_q  <= 1'b0;
               end else begin
                  err_q  <= 1'b1;
               end
            end
         end else if (idle_ok && (cmd_data == SETUP_CODE)) begin
            armed_q <= 1'b1;
         end
      end
   end

   assign mode_o = mode_q;
   assign err_o  = err_q;

   // R4: a refused write leaves mode and error untouched
   p_refuse_keeps_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_wr && !idle_ok) |=> ($stable(mode_q) && $stable(err_q)));

   // R5: invalid code flags an error and keeps the mode
   p_bad_code_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_wr && armed_q && idle_ok && (cmd_data > MAX_CODE)) |=> (err_q && $stable(mode_q)));

   // R6: error is sticky while no write arrives
   p_err_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (err_q && !cmd_wr) |=> err_q);

   // R12: without arming, the mode cannot move
   p_unarmed_keeps_r12: assert property (@(posedge clk) disable iff (!rst_n)
      (!armed_q) |=> $stable(mode_q));

endmodule

// File: rtl/stsig_evt_qual.sv
module stsig_evt_qual
   import stsig_pkg::*;
(
   input  sts_mode_e mode_i,
   input  logic      erase_done,
   input  logic      prog_done,
   output logic      hit_o
);

   assign hit_o = (erase_done && erase_selected(mode_i)) ||
                  (prog_done  && prog_selected(mode_i));

endmodule

// File: rtl/stsig_pulse_tmr.sv
module stsig_pulse_tmr #(
   parameter int unsigned PULSE_CYC = 50
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clr,
   input  logic load,
   output logic active_o
);

   localparam int unsigned CW = $clog2(PULSE_CYC + 1);
   localparam logic [CW-1:0] FULL = CW'(PULSE_CYC);

   logic [CW-1:0] cnt_q;

   always_ff @(posedge clk) begin
      if (!rst_n)              cnt_q <= '0;
      else if (clr)            cnt_q <= '0;
      else if (load)           cnt_q <= FULL;
      else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
   end

   assign active_o = (cnt_q != '0);

   // R7: count never exceeds the pulse width
   p_cnt_range_r7: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q <= FULL);

   // R7: count steps down by one per cycle without a new event
   p_count_down_r7: assert property (@(posedge clk) disable iff (!rst_n)
      ((cnt_q != '0) && !load && !clr) |=> (cnt_q == $past(cnt_q) - 1'b1));

   // R11: a qualifying event reloads the full width
   p_restart_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (load && !clr) |=> (cnt_q == FULL));

   // R13: a mode change ends the pulse
   p_clear_r13: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> (cnt_q == '0));

endmodule

// File: rtl/stsig_pin_ctrl.sv
module stsig_pin_ctrl
   import stsig_pkg::*;
#(
   parameter int unsigned CMD_W      = 8,
   parameter logic [CMD_W-1:0] SETUP_CODE = 8'hB8,
   parameter int unsigned CLK_MHZ    = 200,
   parameter int unsigned PULSE_NS   = 250,
   parameter bit          OUT_REG    = 1'b0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cmd_wr,
   input  logic [CMD_W-1:0] cmd_data,
   input  logic             ctl_busy,
   input  logic             ctl_susp,
   input  logic             erase_done,
   input  logic             prog_done,
   output logic             sts_pin,
   output logic             cfg_err
);

   localparam int unsigned PULSE_CYC = (PULSE_NS * CLK_MHZ) / 1000;

   if (PULSE_CYC < 1) begin : g_bad_width
      $error("pulse width rounds to zero cycles");
   end
   if (CMD_W < 2) begin : g_bad_cmd
      $error("command width too small for mode codes");
   end

   sts_mode_e mode;
   logic      take;
   logic      hit;
   logic      active;
   logic      pin_raw;

   stsig_cmd_dec #(.CMD_W(CMD_W), .SETUP_CODE(SETUP_CODE)) u_dec (
      .clk      (clk),
      .rst_n    (rst_n),
      .cmd_wr   (cmd_wr),
      .cmd_data (cmd_data),
      .ctl_busy (ctl_busy),
      .ctl_susp (ctl_susp),
      .mode_o   (mode),
      .err_o    (cfg_err),
      .take_o   (take)
   );

   stsig_evt_qual u_qual (
      .mode_i     (mode),
      .erase_done (erase_done),
      .prog_done  (prog_done),
      .hit_o      (hit)
   );

   stsig_pulse_tmr #(.PULSE_CYC(PULSE_CYC)) u_tmr (
      .clk      (clk),
      .rst_n    (rst_n),
      .clr      (take),
      .load     (hit),
      .active_o (active)
   );

   assign pin_raw = (mode == MODE_LEVEL) ? !ctl_busy : !active;

   if (OUT_REG) begin : g_out_flop
      logic pin_q;
      always_ff @(posedge clk) begin
         if (!rst_n) pin_q <= 1'b1;
         else        pin_q <= pin_raw;
      end
      assign sts_pin = pin_q;
   end else begin : g_out_comb
      assign sts_pin = pin_raw;
      // R10: in pulse modes the pin never drops without a running pulse
      p_pulse_ignores_busy_r10: assert property (@(posedge clk) disable iff (!rst_n)
         ((mode != MODE_LEVEL) && !active) |-> sts_pin);
   end

endmodule

// File: tb/tb_stsig_pin_ctrl.sv
module tb_stsig_pin_ctrl;

   localparam int P = 4;
   localparam logic [7:0] SETUP = 8'hB8;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic cmd_wr = 1'b0;
   logic [7:0] cmd_data = '0;
   logic ctl_busy = 1'b0, ctl_susp = 1'b0, erase_done = 1'b0, prog_done = 1'b0;
   logic sts_pin, cfg_err;

   int n_run = 0, n_fail = 0, cyc = 0;

   always #2.5 clk = ~clk;

   stsig_pin_ctrl #(.CMD_W(8), .SETUP_CODE(SETUP), .CLK_MHZ(200), .PULSE_NS(20)) dut (
      .clk(clk), .rst_n(rst_n), .cmd_wr(cmd_wr), .cmd_data(cmd_data),
      .ctl_busy(ctl_busy), .ctl_susp(ctl_susp), .erase_done(erase_done),
      .prog_done(prog_done), .sts_pin(sts_pin), .cfg_err(cfg_err));

   always @(posedge clk) begin
      cyc++;
      if (cyc > 190000) begin
         n_fail++; n_run++;
         $display("FAIL watchdog: act %0d cycles exp fewer", cyc);
         $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

   task automatic check(string req, int act, int exp);
      n_run++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s: act %0d exp %0d", req, act, exp);
      end
   endtask

   task automatic wr(logic [7:0] d);
      cmd_wr = 1'b1; cmd_data = d;
      @(negedge clk);
      cmd_wr = 1'b0; cmd_data = '0;
   endtask

   task automatic cfg(logic [7:0] code);
      wr(SETUP); wr(code);
   endtask

   // returns 1 if pin went low right after strobe; waits out the pulse
   task automatic strobe(bit er, output bit low);
      erase_done = er; prog_done = !er;
      @(negedge clk);
      erase_done = 1'b0; prog_done = 1'b0;
      low = !sts_pin;
      repeat (P + 1) @(negedge clk);
   endtask

   task automatic probe(output int m);
      bit e, p, b;
      ctl_busy = 1'b1; #1; b = !sts_pin; ctl_busy = 1'b0; #1;
      strobe(1'b1, e); strobe(1'b0, p);
      if (b) m = 0;
      else if (e && p) m = 3;
      else if (e) m = 1;
      else if (p) m = 2;
      else m = -1;
   endtask

   task automatic width(bit er, bit again, output int w);
      w = 0;
      erase_done = er; prog_done = !er;
      @(negedge clk);
      erase_done = 1'b0; prog_done = 1'b0;
      if (!sts_pin) w++;
      @(negedge clk);
      if (!sts_pin) w++;
      if (again) begin
         erase_done = er; prog_done = !er;
         @(negedge clk);
         erase_done = 1'b0; prog_done = 1'b0;
         if (!sts_pin) w++;
      end
      for (int i = 0; i < P + 3; i++) begin
         @(negedge clk);
         if (!sts_pin) w++;
      end
   endtask

   initial begin
      int m, w;
      bit lo;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      check("R1 err", cfg_err, 0);
      check("R1 pin idle", sts_pin, 1);
      probe(m); check("R1 mode", m, 0);
      // R2 level mode follows busy, strobes ignored
      ctl_busy = 1'b1; #1; check("R2 busy low", sts_pin, 0);
      ctl_busy = 1'b0; #1; check("R2 idle high", sts_pin, 1);
      width(1'b1, 1'b0, w); check("R2 strobe ignored", w, 0);

      // R3 R5: sweep every second-write value
      for (int c = 0; c < 256; c++) begin
         cfg(8'd0);
         cfg(8'(c));
         check(c > 3 ? "R5 err set" : "R3 err clear", cfg_err, (c > 3) ? 1 : 0);
         probe(m);
         check(c > 3 ? "R5 mode kept" : "R3 mode", m, (c > 3) ? 0 : c);
      end

      // R6 error sticky until successful selection
      cfg(8'd2); cfg(8'd77);
      check("R6 err set", cfg_err, 1);
      wr(8'h12); wr(8'h00);
      check("R6 err held", cfg_err, 1);
      probe(m); check("R6 mode kept", m, 2);
      cfg(8'd1);
      check("R6 err cleared", cfg_err, 0);

      // R7 R8 R9 pulse widths and selectivity
      width(1'b1, 1'b0, w); check("R7 erase width", w, P);
      width(1'b0, 1'b0, w); check("R7 prog ignored", w, 0);
      cfg(8'd2);
      width(1'b0, 1'b0, w); check("R8 prog width", w, P);
      width(1'b1, 1'b0, w); check("R8 erase ignored", w, 0);
      cfg(8'd3);
      width(1'b1, 1'b0, w); check("R9 erase width", w, P);
      width(1'b0, 1'b0, w); check("R9 prog width", w, P);
      // R11 restart
      width(1'b0, 1'b1, w); check("R11 restart width", w, P + 2);
      // R10 busy ignored in pulse mode
      ctl_busy = 1'b1; #1; check("R10 busy ignored", sts_pin, 1);
      ctl_busy = 1'b0; #1;

      // R4 refusal at first write (busy), at first write (suspend), at second write
      cfg(8'd3);
      ctl_busy = 1'b1; cfg(8'd1); ctl_busy = 1'b0;
      check("R4 busy err", cfg_err, 0);
      probe(m); check("R4 busy mode", m, 3);
      ctl_susp = 1'b1; cfg(8'd2); ctl_susp = 1'b0;
      probe(m); check("R4 susp mode", m, 3);
      wr(SETUP); ctl_busy = 1'b1; wr(8'd9); ctl_busy = 1'b0;
      check("R4 second refused err", cfg_err, 0);
      // R12 after refusal, next write is a first write again
      wr(8'd1);
      probe(m); check("R12 no arm after refusal", m, 3);
      wr(8'd2); wr(8'd0);
      probe(m); check("R12 stray writes", m, 3);

      // R13 selection cuts an active pulse
      prog_done = 1'b1; @(negedge clk); prog_done = 1'b0;
      check("R13 pulse started", sts_pin, 0);
      cfg(8'd1);
      check("R13 pulse cut", sts_pin, 1);

      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

endmodule